// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block is a serial memory target for a two-wire bus with an open-drain data line. It holds a byte-wide array of `2**ADDR_W` locations. Product builds set `ADDR_W` to 14 for 16K×8 or to 15 for 32K×8. The default is kept small so that elaboration stays light. The clock line and data line come in from the pads as raw levels. They are resynchronised to the system clock, and START and STOP are detected from the sampled levels. The only pad-side output is an enable that pulls the data line low.

A master addresses the device with a select byte. Three static chip-select inputs choose which of up to eight devices answers; unconnected chip-select inputs must be tied to 0. After a write select, two address bytes follow and then up to one page of data bytes. The data bytes are collected in a page buffer. A STOP then starts a self-timed write cycle, and during that cycle the device ignores the bus. A read select returns bytes starting at the internal address counter. A random read loads that counter with a dummy write followed by a repeated START. A sequential read continues for as long as the master acknowledges.

The write-lock input blocks all changes to the memory without hiding the device from the bus.

Top module: `eepromTarget`

## Requirements
- R1: After reset the device does not pull the data line low, and it stays idle until a START is seen.
- R2: In the select byte (sent MSB first), bits 3..1 must equal `chipSel[2:0]`, with bit 3 compared to `chipSel[2]`. Bit 0 is the direction: 0 means write and 1 means read. On a match the device pulls the data line low for the whole ninth clock.
- R3: Bits 7..4 of the select byte must be 4'b1010. On any mismatch the device does not acknowledge, and it keeps the data line released until the next START.
- R4: The device samples data on the rising clock edge. It changes its own drive only while the clock is low.
- R5: A write frame carries two address bytes after the select byte, high byte first. Both are acknowledged. Address bits at and above `ADDR_W` are ignored.
- R6: Each data byte of a write frame is acknowledged and stored at consecutive addresses.
- R7: During a write frame only the low `PAGE_W` address bits advance. After the last byte of a page they wrap to the first byte of the same page, and a later byte replaces an earlier one.
- R8: While `writeLock` is high, the select and address bytes are still acknowledged. Data bytes are not acknowledged, the memory keeps its contents, and no write cycle starts.
- R9: A STOP that ends a frame with at least one accepted data byte starts a write cycle of `WR_CYCLES` clocks. During this cycle the device acknowledges nothing, so a master can poll until an acknowledge returns.
- R10: A write cycle changes only the locations that received a byte. All other bytes of the page keep their values.
- R11: Read data is driven MSB first. Every byte the master acknowledges is followed by the byte at the next address. A not-acknowledge ends the read and the device releases the line.
- R12: The address counter advances past every byte read and wraps from the last location to 0. A read without an address starts at the location after the last one accessed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Serial clock level from the pad |
| sdaIn | input | 1 | Serial data level from the pad (wired-AND bus value) |
| chipSel | input | 3 | Device address selection, compared with select bits 3..1 |
| writeLock | input | 1 | High blocks every memory change |
| sdaDriveLow | output | 1 | High pulls the data line low (open-drain enable) |

## Verification
The hardest case to reach is the wrap of a page write. The frame must start near the end of a page and run past it. The bytes already in that page must also be known beforehand, so that overwritten locations can be told apart from untouched ones. The stimulus first fills part of a page, waits out the write cycle by polling, and then writes across the page end. A sequential read then covers both edges of the page. Address wrap at the top of memory is reached in a similar way: the last location and location 0 are written in separate frames, and one read is then started at the last address.

// File: rtl/eepromPkg.sv
package eepromPkg;

  // Fixed device-type code expected in select bits 7..4
  localparam logic [3:0] SEL_PATTERN = 4'b1010;

  typedef enum logic [2:0] {
    M_IDLE,
    M_SEL,
    M_AHI,
    M_ALO,
    M_WDATA,
    M_RDATA
  } busModeT;

  // Strobes from the bus control to the storage datapath
  typedef struct packed {
    logic shiftIn;     // shift bitVal into the receive register
    logic bitVal;
    logic loadHi;      // latch high address byte
    logic loadLo;      // load address counter
    logic storeByte;   // put received byte into the page buffer
    logic advanceRead; // step the address after a transmitted byte
    logic clearPage;   // drop pending page contents
    logic startCommit; // begin moving the page buffer into memory
  } ctrlStrobeT;

endpackage

// File: rtl/eepromCtrl.sv
module eepromCtrl
  import eepromPkg::*;
#(
  parameter int WR_CYCLES = 300
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [2:0] chipSel,
  input  logic       writeLock,
  input  logic [7:0] rxByte,
  input  logic [7:0] rdByte,
  output ctrlStrobeT stb,
  output logic       sdaLow
);

  localparam int WAIT_W = $clog2(WR_CYCLES);

  logic [1:0] sclSync, sdaSync;
  logic sclPrev, sdaPrev, sclNow, sdaNow;
  logic sclRise, sclFall, startEv, stopEv;

  busModeT mode, modeN, nextMode, nextModeN;
  logic [3:0] bitCnt, bitCntN;
  logic busy, busyN, pending, pendingN, sdaLowN;
  logic [WAIT_W-1:0] waitCnt, waitCntN;
  logic [3:0] txIdx;

  assign sclNow  = sclSync[1];
  assign sdaNow  = sdaSync[1];
  assign sclRise = sclNow & ~sclPrev;
  assign sclFall = ~sclNow & sclPrev;
  assign startEv = sclNow & sclPrev & sdaPrev & ~sdaNow;
  assign stopEv  = sclNow & sclPrev & ~sdaPrev & sdaNow;
  assign txIdx   = 4'd7 - bitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclPrev <= sclNow;
      sdaPrev <= sdaNow;
    end
  end

  always_comb begin
    modeN     = mode;
    nextModeN = nextMode;
    bitCntN   = bitCnt;
    busyN     = busy;
    waitCntN  = waitCnt;
    pendingN  = pending;
    sdaLowN   = sdaLow;
    stb       = '0;
    if (busy) begin
      // self-timed write: the bus is not observed at all
      modeN   = M_IDLE;
      sdaLowN = 1'b0;
      if (waitCnt == WAIT_W'(WR_CYCLES - 1)) begin
        busyN    = 1'b0;
        waitCntN = '0;
      end else begin
        waitCntN = waitCnt + 1'b1;
      end
    end else if (startEv) begin
      modeN         = M_SEL;
      bitCntN       = '0;
      sdaLowN       = 1'b0;
      pendingN      = 1'b0;
      stb.clearPage = 1'b1;
    end else if (stopEv) begin
      modeN   = M_IDLE;
      sdaLowN = 1'b0;
      if (pending) begin
        busyN           = 1'b1;
        waitCntN        = '0;
        pendingN        = 1'b0;
        stb.startCommit = 1'b1;
      end
    end else if (mode != M_IDLE) begin
      if (sclRise) begin
        if (bitCnt != 4'd8) begin
          bitCntN = bitCnt + 4'd1;
          if (mode != M_RDATA) begin
            stb.shiftIn = 1'b1;
            stb.bitVal  = sdaNow;
          end
        end else begin
          // ninth clock: acknowledge slot
          bitCntN = '0;
          if (mode == M_RDATA) begin
            stb.advanceRead = 1'b1;
            if (sdaNow) modeN = M_IDLE;
          end else begin
            modeN = nextMode;
          end
        end
      end else if (sclFall) begin
        if (bitCnt == 4'd8) begin
          if (mode == M_RDATA) begin
            sdaLowN = 1'b0;
          end else begin
            case (mode)
              M_SEL: begin
                if (rxByte[7:4] == SEL_PATTERN && rxByte[3:1] == chipSel) begin
                  sdaLowN   = 1'b1;
                  nextModeN = rxByte[0] ? M_RDATA : M_AHI;
                end else begin
                  modeN = M_IDLE;
                end
              end
              M_AHI: begin
                sdaLowN    = 1'b1;
                stb.loadHi = 1'b1;
                nextModeN  = M_ALO;
              end
              M_ALO: begin
                sdaLowN    = 1'b1;
                stb.loadLo = 1'b1;
                nextModeN  = M_WDATA;
              end
              M_WDATA: begin
                nextModeN = M_WDATA;
                if (!writeLock) begin
                  sdaLowN       = 1'b1;
                  stb.storeByte = 1'b1;
                  pendingN      = 1'b1;
                end
              end
              default: ;
            endcase
          end
        end else if (mode == M_RDATA) begin
          sdaLowN = ~rdByte[txIdx[2:0]];
        end else begin
          sdaLowN = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode     <= M_IDLE;
      nextMode <= M_IDLE;
      bitCnt   <= '0;
      busy     <= 1'b0;
      waitCnt  <= '0;
      pending  <= 1'b0;
      sdaLow   <= 1'b0;
    end else begin
      mode     <= modeN;
      nextMode <= nextModeN;
      bitCnt   <= bitCntN;
      busy     <= busyN;
      waitCnt  <= waitCntN;
      pending  <= pendingN;
      sdaLow   <= sdaLowN;
    end
  end

  // R9: nothing is driven while the internal write runs
  assert_quiet_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !sdaLow);

  // R9: a write cycle is only entered from a STOP
  assert_busy_after_stop_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(stopEv));

  // R4: the pull-down is engaged only after a low clock was seen
  assert_drive_scl_low_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaLow) |-> !$past(sclNow));

endmodule

// File: rtl/eepromData.sv
module eepromData
  import eepromPkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int PAGE_W = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  ctrlStrobeT stb,
  output logic [7:0] rxByte,
  output logic [7:0] rdByte
);

  localparam int DEPTH      = 1 << ADDR_W;
  localparam int PAGE_BYTES = 1 << PAGE_W;

  logic [7:0] mem [DEPTH];
  logic [7:0] pageBuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pageValid;
  logic [7:0] rxShift;
  logic [ADDR_W-9:0] addrHi;
  logic [ADDR_W-1:0] addrCnt;
  logic [PAGE_W-1:0] commitIdx;
  logic commitOn;
  logic [ADDR_W-PAGE_W-1:0] pageNum;

  assign rxByte  = rxShift;
  assign pageNum = addrCnt[ADDR_W-1:PAGE_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift   <= '0;
      addrHi    <= '0;
      addrCnt   <= '0;
      pageValid <= '0;
      commitIdx <= '0;
      commitOn  <= 1'b0;
    end else begin
      if (stb.shiftIn) rxShift <= {rxShift[6:0], stb.bitVal};
      if (stb.loadHi) addrHi <= rxShift[ADDR_W-9:0];
      if (stb.loadLo) addrCnt <= {addrHi, rxShift};
      if (stb.storeByte) begin
        pageValid[addrCnt[PAGE_W-1:0]] <= 1'b1;
        addrCnt[PAGE_W-1:0] <= addrCnt[PAGE_W-1:0] + 1'b1;
      end
      if (stb.advanceRead) addrCnt <= addrCnt + 1'b1;
      if (stb.clearPage) pageValid <= '0;
      if (stb.startCommit) begin
        commitOn  <= 1'b1;
        commitIdx <= '0;
      end else if (commitOn) begin
        commitIdx <= commitIdx + 1'b1;
        if (&commitIdx) begin
          commitOn  <= 1'b0;
          pageValid <= '0;
        end
      end
    end
  end

  // storage without reset
  always_ff @(posedge clk) begin
    if (stb.storeByte) pageBuf[addrCnt[PAGE_W-1:0]] <= rxShift;
    if (commitOn && pageValid[commitIdx]) mem[{pageNum, commitIdx}] <= pageBuf[commitIdx];
    rdByte <= mem[addrCnt];
  end

  // R7: storing a byte never leaves the current page
  assert_page_kept_R7: assert property (@(posedge clk) disable iff (!rstN)
    stb.storeByte |=> addrCnt[ADDR_W-1:PAGE_W] == $past(addrCnt[ADDR_W-1:PAGE_W]));

  // R12: every transmitted byte steps the address by one, modulo depth
  assert_read_step_R12: assert property (@(posedge clk) disable iff (!rstN)
    stb.advanceRead |=> addrCnt == $past(addrCnt) + 1'b1);

  // R9: no byte is accepted while a page is being committed
  assert_no_store_commit_R9: assert property (@(posedge clk) disable iff (!rstN)
    stb.storeByte |-> !commitOn);

endmodule

// File: rtl/eepromTarget.sv
module eepromTarget
  import eepromPkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int PAGE_W    = 6,
  parameter int WR_CYCLES = 300
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [2:0] chipSel,
  input  logic       writeLock,
  output logic       sdaDriveLow
);

  ctrlStrobeT stb;
  logic [7:0] rxByte, rdByte;

  eepromCtrl #(.WR_CYCLES(WR_CYCLES)) uCtrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .chipSel(chipSel), .writeLock(writeLock),
    .rxByte(rxByte), .rdByte(rdByte), .stb(stb), .sdaLow(sdaDriveLow)
  );

  eepromData #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .rxByte(rxByte), .rdByte(rdByte)
  );

endmodule

// File: tb/sim_eepromTarget.sv
module sim_eepromTarget;
  localparam int ADDR_W = 10;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int PAGE   = 64;
  localparam int Q      = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN = 1'b0;
  logic masterScl = 1'b1, masterSda = 1'b1;
  logic [2:0] chipSel = 3'b101;
  logic writeLock = 1'b0;
  logic sdaDriveLow;
  wire  sdaBus = masterSda & ~sdaDriveLow;

  int checks = 0, errors = 0, quietHits = 0;
  bit expectQuiet = 1'b0;
  logic [7:0] refMem [int];
  int refAddr = 0;

  eepromTarget #(.ADDR_W(ADDR_W), .PAGE_W(6), .WR_CYCLES(300)) u0 (
    .clk(clk), .rstN(rstN), .sclIn(masterScl), .sdaIn(sdaBus),
    .chipSel(chipSel), .writeLock(writeLock), .sdaDriveLow(sdaDriveLow)
  );

  // per-clock comparison against the model's "device must be silent" window
  always @(negedge clk) if (expectQuiet && sdaDriveLow) quietHits++;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic startCond();
    masterSda = 1'b1; waitQ(); masterScl = 1'b1; waitQ();
    masterSda = 1'b0; waitQ(); masterScl = 1'b0; waitQ();
  endtask

  task automatic stopCond();
    masterSda = 1'b0; waitQ(); masterScl = 1'b1; waitQ();
    masterSda = 1'b1; waitQ();
  endtask

  task automatic sendByte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      masterSda = b[i]; waitQ(); masterScl = 1'b1; waitQ(); waitQ();
      masterScl = 1'b0; waitQ();
    end
    masterSda = 1'b1; waitQ(); masterScl = 1'b1; waitQ();
    ack = (sdaBus == 1'b0);
    waitQ(); masterScl = 1'b0; waitQ();
  endtask

  task automatic recvByte(input bit giveAck, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      masterSda = 1'b1; waitQ(); masterScl = 1'b1; waitQ();
      b[i] = sdaBus;
      waitQ(); masterScl = 1'b0; waitQ();
    end
    masterSda = giveAck ? 1'b0 : 1'b1; waitQ(); masterScl = 1'b1; waitQ(); waitQ();
    masterScl = 1'b0; waitQ(); masterSda = 1'b1;
  endtask

  function automatic logic [7:0] sel(input logic rw);
    return {4'b1010, chipSel, rw};
  endfunction

  // write frame; data bytes packed MSB-first in d
  task automatic doWrite(input int addr, input int n, input logic [31:0] d, input bit locked);
    bit ack;
    int base, off;
    startCond();
    sendByte(sel(1'b0), ack); check(ack, "R4 select ack", ack, 1);
    sendByte(addr[15:8], ack); check(ack, "R5 addr high ack", ack, 1);
    sendByte(addr[7:0], ack);  check(ack, "R5 addr low ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      sendByte(d[31-8*i -: 8], ack);
      if (locked) check(!ack, "R8 data nack", ack, 0);
      else        check(ack, "R6 data ack", ack, 1);
    end
    stopCond();
    base = addr & (DEPTH - 1) & ~(PAGE - 1);
    off  = addr & (PAGE - 1);
    if (!locked) begin
      for (int i = 0; i < n; i++) refMem[base | ((off + i) % PAGE)] = d[31-8*i -: 8];
      refAddr = base | ((off + n) % PAGE);
    end else begin
      refAddr = addr & (DEPTH - 1);
    end
  endtask

  task automatic pollDone();
    bit ack = 1'b0;
    int polls = 0;
    while (!ack && polls < 20) begin
      startCond(); sendByte(sel(1'b0), ack); stopCond();
      if (!ack) polls++;
    end
    check(polls > 0, "R9 busy no ack", polls, 1);
    check(ack, "R9 ack returns", ack, 1);
  endtask

  // addr < 0 means current-address read
  task automatic readSeq(input int addr, input int n, input string tag);
    bit ack;
    logic [7:0] b;
    if (addr >= 0) begin
      startCond();
      sendByte(sel(1'b0), ack);
      sendByte(addr[15:8], ack);
      sendByte(addr[7:0], ack);
      refAddr = addr & (DEPTH - 1);
    end
    startCond();
    sendByte(sel(1'b1), ack); check(ack, "R2 read select ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      recvByte(i < n - 1, b);
      check(b === refMem[refAddr], tag, b, refMem[refAddr]);
      refAddr = (refAddr + 1) % DEPTH;
    end
    stopCond();
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    bit ack;
    repeat (5) @(negedge clk);
    check(sdaDriveLow == 1'b0, "R1 reset release", sdaDriveLow, 0);
    rstN = 1'b1;
    repeat (20) @(negedge clk);
    check(sdaDriveLow == 1'b0, "R1 idle release", sdaDriveLow, 0);

    // single byte, upper address bits set above ADDR_W
    doWrite(16'h0123, 1, 32'h5A000000, 1'b0); pollDone();
    readSeq(16'h0123, 1, "R11 random read");
    doWrite(16'hFC05, 1, 32'h77000000, 1'b0); pollDone();
    readSeq(16'h0005, 1, "R5 upper bits ignored");

    // page write and sequential read
    doWrite(16'h0040, 4, 32'h11223344, 1'b0); pollDone();
    readSeq(16'h0040, 4, "R11 sequential read");

    // write across the page end
    doWrite(16'h007E, 4, 32'hA1A2A3A4, 1'b0); pollDone();
    readSeq(16'h007E, 2, "R7 page tail");
    readSeq(16'h0040, 2, "R7 wrapped bytes");
    readSeq(-1, 2, "R10 R12 current read keeps rest");

    // partial rewrite, then current read after write
    doWrite(16'h0200, 3, 32'h10203000, 1'b0); pollDone();
    doWrite(16'h0200, 1, 32'h9A000000, 1'b0); pollDone();
    readSeq(-1, 1, "R12 current after write");
    readSeq(16'h0200, 3, "R10 untouched bytes");

    // write lock
    writeLock = 1'b1;
    doWrite(16'h0123, 1, 32'hEE000000, 1'b1);
    startCond(); sendByte(sel(1'b0), ack); stopCond();
    check(ack, "R8 no write cycle", ack, 1);
    writeLock = 1'b0;
    readSeq(16'h0123, 1, "R8 memory unchanged");

    // mismatched select codes
    startCond();
    expectQuiet = 1'b1;
    sendByte({4'b1010, 3'b001, 1'b0}, ack); check(!ack, "R2 chip select mismatch", ack, 0);
    sendByte(8'h00, ack); check(!ack, "R3 silent until start", ack, 0);
    stopCond();
    expectQuiet = 1'b0;
    check(quietHits == 0, "R3 line released", quietHits, 0);
    startCond();
    sendByte({4'b1011, chipSel, 1'b0}, ack); check(!ack, "R3 type mismatch", ack, 0);
    stopCond();
    startCond();
    sendByte(sel(1'b0), ack); check(ack, "R2 match after mismatch", ack, 1);
    stopCond();

    // wrap from the last location to 0
    doWrite(DEPTH - 1, 1, 32'hC3000000, 1'b0); pollDone();
    doWrite(0, 1, 32'h3C000000, 1'b0); pollDone();
    readSeq(DEPTH - 1, 2, "R12 top wrap");

    finishRun();
  end

endmodule